// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that sits on a simple valid/ready register bus. It holds a 32-bit up-counter. The counter advances on a slow tick, which arrives as a tick-enable input, and it can pass through an optional power-of-two prescaler on the way. Software keeps the system alive by writing the trigger register. Each trigger write reloads the counter from the load register. The counter counts upward, so a smaller load value gives a longer time to expiry. If software stops writing the trigger and the running counter steps past its all-ones value, the block emits a one-cycle reset pulse. The counter then restarts from the load value.

Software cannot start or stop the timer with a single write. It must write a matched pair of key words to the key register. To start the timer, it writes 0xBBBB and then 0x4444. To stop it, it writes 0xAAAA and then 0x5555. A wrong partner word, or a write to any other register between the two words, abandons the pair.

Writes to the control, load, trigger and key registers are posted. Each one takes effect a fixed number of cycles after it is accepted. While it waits, a pending-status register flags it.

The key sequencer is a three-state machine:
- `KEY_IDLE`: no first word has been seen.
- `KEY_ARM_START`: 0xBBBB has been seen.
- `KEY_ARM_STOP`: 0xAAAA has been seen.

It has the following transitions:
- IDLE goes to ARM_START on 0xBBBB.
- IDLE goes to ARM_STOP on 0xAAAA.
- ARM_START goes back to IDLE on any key word, and the timer starts if that word is 0x4444.
- ARM_STOP goes back to IDLE on any key word, and the timer stops if that word is 0x5555.
- Both ARM states return to IDLE when any other register is written.
- Any other word seen in IDLE leaves the machine in IDLE.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the timer is stopped, the counter and load register read 0, the pending register reads 0 and no reset pulse is emitted; ticks leave the counter unchanged.
- R2: A write accepted to control (0x24), load (0x2C), trigger (0x30) or key (0x48) sets its bit in the pending register (0x34) for POST_DELAY cycles. The bits are: control bit 0, load bit 2, trigger bit 3, key bit 4. The write takes effect only when that bit clears, so a read in the meantime returns the old value.
- R3: A write to a posted register while its pending bit is set is ignored.
- R4: Key words 0xBBBB then 0x4444 (low 16 bits of the write) start the timer; a running counter with the prescaler off advances by one per tick.
- R5: Key words 0xAAAA then 0x5555 stop the timer; the counter then holds its value under ticks.
- R6: A first key word followed by a word that is not its partner, or by a write to another register, discards the pair; the running state is unchanged.
- R7: A committed trigger write loads the counter (0x28) from the load register and clears the prescaler phase.
- R8: Control bit 5 enables the prescaler and bits 4:2 hold the ratio r; when enabled the counter advances once every 2^(r+1) ticks. Control reads back these fields in place.
- R9: When a running counter at 0xFFFFFFFF steps, the output wdt_reset is high for exactly one cycle and the counter reloads from the load register.
- R10: The revision register (0x00) returns REVISION in its low byte; system config (0x10) bit 0 is written immediately and reads back as written.
- R11: A read accepted at one edge returns its data on rd_data, with rd_valid high, in the following cycle; bus_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow functional tick, one cycle per tick |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always high) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| wdt_reset | output | 1 | One-cycle reset pulse on expiry |

## Verification
The assertions take for granted that bus_valid, bus_write and tick_en are clean, synchronous single-bit levels that are never unknown after reset. They also assume POST_DELAY is at least 1, so each posted slot has a well-defined commit cycle. The stimulus drives every input on the falling edge and holds tick_en low during register reads, so the counter value that is sampled is stable. Every check waits out the posted delay before it relies on a committed value, except the deliberate checks that read while a write is still pending.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_REV    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SYSCFG = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_LOAD   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_TRIG   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_KEY    = 8'h48;

    localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
    localparam logic [15:0] KEY_ON_B  = 16'h4444;
    localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_B = 16'h5555;

    localparam int NUM_SLOTS = 4;
    localparam int SLOT_CTRL = 0;
    localparam int SLOT_LOAD = 1;
    localparam int SLOT_TRIG = 2;
    localparam int SLOT_KEY  = 3;

    typedef enum logic [1:0] {
        KEY_IDLE      = 2'd0,
        KEY_ARM_START = 2'd1,
        KEY_ARM_STOP  = 2'd2
    } key_state_e;

    function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
        case (idx)
            SLOT_CTRL: return OFF_CTRL;
            SLOT_LOAD: return OFF_LOAD;
            SLOT_TRIG: return OFF_TRIG;
            default:   return OFF_KEY;
        endcase
    endfunction

    function automatic int slot_pend_bit(input int idx);
        case (idx)
            SLOT_CTRL: return 0;
            SLOT_LOAD: return 2;
            SLOT_TRIG: return 3;
            default:   return 4;
        endcase
    endfunction
endpackage

// File: rtl/kwd_post_slot.sv
module kwd_post_slot #(
    parameter int DW    = 32,
    parameter int DELAY = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    output logic          pending,
    output logic          commit,
    output logic [DW-1:0] data_q
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt_q   <= '0;
            data_q  <= '0;
        end else if (!pending) begin
            if (wr_hit) begin
                pending <= 1'b1;
                cnt_q   <= CW'(DELAY);
                data_q  <= wr_data;
            end
        end else if (cnt_q == CW'(1)) begin
            pending <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign commit = pending && (cnt_q == CW'(1));

    // A fresh write opens a full delay window
    assert_post_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !pending) |=> (pending && cnt_q == CW'(DELAY)));

    // A write landing on a busy slot leaves the captured word alone
    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && pending) |=> $stable(data_q));
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_commit,
    input  logic [15:0] key_word,
    input  logic        other_wr,
    output logic        running
);
    key_state_e state_q, state_d;
    logic       run_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
            running <= 1'b0;
        end else begin
            state_q <= state_d;
            running <= run_d;
        end
    end

    always_comb begin
        state_d = state_q;
        run_d   = running;
        if (key_commit) begin
            unique case (state_q)
                KEY_IDLE: begin
                    if (key_word == KEY_ON_A)       state_d = KEY_ARM_START;
                    else if (key_word == KEY_OFF_A) state_d = KEY_ARM_STOP;
                end
                KEY_ARM_START: begin
                    state_d = KEY_IDLE;
                    if (key_word == KEY_ON_B) run_d = 1'b1;
                end
                KEY_ARM_STOP: begin
                    state_d = KEY_IDLE;
                    if (key_word == KEY_OFF_B) run_d = 1'b0;
                end
                default: state_d = KEY_IDLE;
            endcase
        end else if (other_wr) begin
            state_d = KEY_IDLE;
        end
    end

    // Running state moves only when a key word commits
    assert_run_keyed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running != $past(running)) |-> $past(key_commit));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               running,
    input  logic               ctrl_wr,
    input  logic               pre_en_in,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               load_wr,
    input  logic [CNT_W-1:0]   load_in,
    input  logic               trig_wr,
    output logic [CNT_W-1:0]   count_q,
    output logic [CNT_W-1:0]   load_q,
    output logic               pre_en_q,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               wd_pulse
);
    localparam int PRE_W = 1 << RATIO_W;

    logic [PRE_W-1:0] pre_cnt_q;
    logic [PRE_W-1:0] pre_lim;

    assign pre_lim = ~({PRE_W{1'b1}} << (int'(ratio_q) + 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            load_q    <= '0;
            pre_en_q  <= 1'b0;
            ratio_q   <= '0;
            pre_cnt_q <= '0;
            wd_pulse  <= 1'b0;
        end else begin
            wd_pulse <= 1'b0;
            if (trig_wr) begin
                count_q   <= load_q;
                pre_cnt_q <= '0;
            end else if (running && tick_en) begin
                if (pre_en_q && pre_cnt_q != pre_lim) begin
                    pre_cnt_q <= pre_cnt_q + 1'b1;
                end else begin
                    pre_cnt_q <= '0;
                    if (count_q == {CNT_W{1'b1}}) begin
                        count_q  <= load_q;
                        wd_pulse <= 1'b1;
                    end else begin
                        count_q <= count_q + 1'b1;
                    end
                end
            end
            if (ctrl_wr) begin
                pre_en_q <= pre_en_in;
                ratio_q  <= ratio_in;
            end
            if (load_wr) load_q <= load_in;
        end
    end

    // A stopped counter holds unless a trigger reloads it
    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !trig_wr) |=> $stable(count_q));

    // Expiry pulse only comes from a running counter
    assert_pulse_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pulse |-> $past(running));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int          POST_DELAY = 4,
    parameter logic [7:0]  REVISION   = 8'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_reset
);
    localparam int RATIO_W = 3;

    logic                  wr_acc, rd_acc, other_wr;
    logic [NUM_SLOTS-1:0]  slot_hit, slot_pend, slot_commit;
    logic [DATA_W-1:0]     slot_data [NUM_SLOTS];
    logic [4:0]            pend_vec;
    logic                  sys_autogate_q;
    logic                  running;
    logic [DATA_W-1:0]     count_q, load_q;
    logic                  pre_en_q;
    logic [RATIO_W-1:0]    ratio_q;
    logic [DATA_W-1:0]     rd_mux;

    assign bus_ready = 1'b1;
    assign wr_acc    = bus_valid && bus_write;
    assign rd_acc    = bus_valid && !bus_write;
    assign other_wr  = wr_acc && (bus_addr != OFF_KEY);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign slot_hit[i] = wr_acc && (bus_addr == slot_addr(i));
        kwd_post_slot #(.DW(DATA_W), .DELAY(POST_DELAY)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (slot_hit[i]),
            .wr_data (bus_wdata),
            .pending (slot_pend[i]),
            .commit  (slot_commit[i]),
            .data_q  (slot_data[i])
        );
    end

    always_comb begin
        pend_vec = '0;
        for (int i = 0; i < NUM_SLOTS; i++) pend_vec[slot_pend_bit(i)] = slot_pend[i];
    end

    kwd_keyseq u_keyseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_commit (slot_commit[SLOT_KEY]),
        .key_word   (slot_data[SLOT_KEY][15:0]),
        .other_wr   (other_wr),
        .running    (running)
    );

    kwd_counter #(.CNT_W(DATA_W), .RATIO_W(RATIO_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .running   (running),
        .ctrl_wr   (slot_commit[SLOT_CTRL]),
        .pre_en_in (slot_data[SLOT_CTRL][5]),
        .ratio_in  (slot_data[SLOT_CTRL][4:2]),
        .load_wr   (slot_commit[SLOT_LOAD]),
        .load_in   (slot_data[SLOT_LOAD]),
        .trig_wr   (slot_commit[SLOT_TRIG]),
        .count_q   (count_q),
        .load_q    (load_q),
        .pre_en_q  (pre_en_q),
        .ratio_q   (ratio_q),
        .wd_pulse  (wdt_reset)
    );

    logic unused_slot_bits;
    assign unused_slot_bits = ^{slot_data[SLOT_CTRL][DATA_W-1:6], slot_data[SLOT_CTRL][1:0],
                                slot_data[SLOT_TRIG], slot_data[SLOT_KEY][DATA_W-1:16]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sys_autogate_q <= 1'b0;
        else if (wr_acc && bus_addr == OFF_SYSCFG) sys_autogate_q <= bus_wdata[0];
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFF_REV:    rd_mux = {{(DATA_W-8){1'b0}}, REVISION};
            OFF_SYSCFG: rd_mux = {{(DATA_W-1){1'b0}}, sys_autogate_q};
            OFF_CTRL:   rd_mux = {{(DATA_W-6){1'b0}}, pre_en_q, ratio_q, 2'b00};
            OFF_COUNT:  rd_mux = count_q;
            OFF_LOAD:   rd_mux = load_q;
            OFF_PEND:   rd_mux = {{(DATA_W-5){1'b0}}, pend_vec};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc) rd_data <= rd_mux;
        end
    end

    // Read response only follows an accepted read
    assert_rd_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write));

    // Key pending flag present whenever the key slot is waiting
    assert_key_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_commit[SLOT_KEY] |-> pend_vec[4]);
endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
    localparam int DELAY = 4;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2;
    localparam logic [7:0] A_REV = 8'h00, A_SYS = 8'h10, A_CTRL = 8'h24, A_CNT = 8'h28,
                           A_LOAD = 8'h2C, A_TRIG = 8'h30, A_PEND = 8'h34, A_KEY = 8'h48;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, A_CNT,  32'h0,     32'h0,   4'd1},  // R1
        '{OP_RD, A_LOAD, 32'h0,     32'h0,   4'd1},  // R1
        '{OP_RD, A_PEND, 32'h0,     32'h0,   4'd1},  // R1
        '{OP_RD, A_REV,  32'h0,     32'h21,  4'd10}, // R10
        '{OP_WR, A_SYS,  32'h1,     32'h0,   4'd10},
        '{OP_RD, A_SYS,  32'h0,     32'h1,   4'd10}, // R10
        '{OP_WR, A_LOAD, 32'h100,   32'h0,   4'd7},
        '{OP_WR, A_TRIG, 32'h1,     32'h0,   4'd7},
        '{OP_RD, A_CNT,  32'h0,     32'h100, 4'd7},  // R7
        '{OP_TK, 8'h0,   32'd10,    32'h0,   4'd1},
        '{OP_RD, A_CNT,  32'h0,     32'h100, 4'd1},  // R1 stopped after reset
        '{OP_WR, A_KEY,  32'hBBBB,  32'h0,   4'd4},
        '{OP_WR, A_KEY,  32'h4444,  32'h0,   4'd4},
        '{OP_TK, 8'h0,   32'd10,    32'h0,   4'd4},
        '{OP_RD, A_CNT,  32'h0,     32'h10A, 4'd4},  // R4
        '{OP_WR, A_CTRL, 32'h24,    32'h0,   4'd8},
        '{OP_WR, A_TRIG, 32'h0,     32'h0,   4'd7},
        '{OP_RD, A_CNT,  32'h0,     32'h100, 4'd7},  // R7
        '{OP_TK, 8'h0,   32'd12,    32'h0,   4'd8},
        '{OP_RD, A_CNT,  32'h0,     32'h103, 4'd8},  // R8 ratio 1: every 4 ticks
        '{OP_RD, A_CTRL, 32'h0,     32'h24,  4'd8},  // R8
        '{OP_WR, A_CTRL, 32'h0,     32'h0,   4'd8},
        '{OP_WR, A_KEY,  32'hAAAA,  32'h0,   4'd6},
        '{OP_WR, A_LOAD, 32'h200,   32'h0,   4'd6},
        '{OP_WR, A_KEY,  32'h5555,  32'h0,   4'd6},
        '{OP_TK, 8'h0,   32'd5,     32'h0,   4'd6},
        '{OP_RD, A_CNT,  32'h0,     32'h108, 4'd6},  // R6 intervening write
        '{OP_WR, A_KEY,  32'hAAAA,  32'h0,   4'd6},
        '{OP_WR, A_KEY,  32'h1234,  32'h0,   4'd6},
        '{OP_WR, A_KEY,  32'h5555,  32'h0,   4'd6},
        '{OP_TK, 8'h0,   32'd2,     32'h0,   4'd6},
        '{OP_RD, A_CNT,  32'h0,     32'h10A, 4'd6},  // R6 wrong partner
        '{OP_WR, A_KEY,  32'hAAAA,  32'h0,   4'd5},
        '{OP_WR, A_KEY,  32'h5555,  32'h0,   4'd5},
        '{OP_TK, 8'h0,   32'd5,     32'h0,   4'd5},
        '{OP_RD, A_CNT,  32'h0,     32'h10A, 4'd5},  // R5
        '{OP_RD, A_LOAD, 32'h0,     32'h200, 4'd2}   // R2 committed value
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, rd_valid, wdt_reset;
    logic [31:0] rd_data;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int cycles = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .wdt_reset(wdt_reset)
    );

    always @(negedge clk) if (wdt_reset) pulses++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: got %0d cycles exp fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h exp 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr_nowait(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_nowait(a, d);
        idle(DELAY);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = rd_data;
        if (!rd_valid) begin
            checks++; errors++;
            $display("FAIL R11: got rd_valid 0 exp 1");
        end
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n - 1) @(negedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk("R1 pulse", 32'(wdt_reset), 32'h0);
        chk("R11 ready", 32'(bus_ready), 32'h1);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: wr(VECS[i].addr, VECS[i].data);
                OP_TK: ticks(int'(VECS[i].data));
                default: begin
                    rd(VECS[i].addr, rv);
                    checks++;
                    if (rv !== VECS[i].exp) begin
                        errors++;
                        $display("FAIL R%0d vec %0d: got 0x%08h exp 0x%08h",
                                 VECS[i].req, i, rv, VECS[i].exp);
                    end
                end
            endcase
        end

        // R2: pending bits and delayed effect
        wr_nowait(A_LOAD, 32'h77);
        rd(A_PEND, rv); chk("R2 load pend", rv, 32'h4);
        rd(A_LOAD, rv); chk("R2 old load", rv, 32'h200);
        idle(DELAY + 2);
        rd(A_PEND, rv); chk("R2 pend clear", rv, 32'h0);
        rd(A_LOAD, rv); chk("R2 new load", rv, 32'h77);
        wr_nowait(A_CTRL, 32'h0);
        rd(A_PEND, rv); chk("R2 ctrl pend", rv, 32'h1);
        idle(DELAY + 2);
        wr_nowait(A_TRIG, 32'h0);
        rd(A_PEND, rv); chk("R2 trig pend", rv, 32'h8);
        idle(DELAY + 2);
        wr_nowait(A_KEY, 32'h0);
        rd(A_PEND, rv); chk("R2 key pend", rv, 32'h10);
        idle(DELAY + 2);
        chk("R11 no rd_valid after write", 32'(rd_valid), 32'h0);

        // R3: second write while pending is dropped
        wr_nowait(A_LOAD, 32'h55);
        wr_nowait(A_LOAD, 32'h66);
        idle(DELAY + 2);
        rd(A_LOAD, rv); chk("R3 busy write ignored", rv, 32'h55);

        // R9: overflow pulse and reload
        wr(A_LOAD, 32'hFFFF_FFF0);
        wr(A_TRIG, 32'h0);
        wr(A_KEY, 32'hBBBB);
        wr(A_KEY, 32'h4444);
        pulses = 0;
        ticks(15);
        rd(A_CNT, rv); chk("R9 at max", rv, 32'hFFFF_FFFF);
        chk("R9 no early pulse", 32'(pulses), 32'h0);
        ticks(1);
        idle(2);
        chk("R9 one pulse", 32'(pulses), 32'h1);
        rd(A_CNT, rv); chk("R9 reload", rv, 32'hFFFF_FFF0);

        // R1: reset in mid-run
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        rd(A_CNT, rv);  chk("R1 count after reset", rv, 32'h0);
        rd(A_LOAD, rv); chk("R1 load after reset", rv, 32'h0);
        rd(A_PEND, rv); chk("R1 pend after reset", rv, 32'h0);
        ticks(5);
        rd(A_CNT, rv);  chk("R1 stopped after reset", rv, 32'h0);
        chk("R1 no pulse after reset", 32'(pulses), 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule